// File: doc/BRIEF.md
# Register Rename Map with Free List

This block renames one instruction per cycle. It maps each logical register onto a larger pool of physical registers. A speculative map table translates the two source operands and the destination of the incoming instruction. A FIFO of unassigned physical register numbers supplies a fresh physical register for every destination. The map is then updated so that later instructions read the new name. The rename also returns the physical register the destination held before. The caller keeps that number with the instruction and hands it back through the release port when the instruction commits.

A second table holds the committed mapping and is updated at every release. When the pipeline discards speculative work, a flush copies the committed table into the speculative one. The same flush rebuilds the free list from every physical register the committed table does not use, in ascending order. Each destination always gets a new register, and sources are read before the destination is remapped. As a result, two instructions that write the same logical register never conflict on storage.

Top module: `rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical register i, the free list holds physical registers NUM_LOG up to NUM_PHYS-1 in ascending order (head first), and `ren_ready` is high.
- R2: `ren_phys_a` and `ren_phys_b` give the mapping of `ren_src_a` and `ren_src_b` as it stood before the current instruction. This holds even when a source equals the destination of the same instruction.
- R3: A rename that fires (`ren_valid` and `ren_ready` high, `flush` low) gets the head of the free list on `ren_phys_dst`. Registers leave the free list in the order they entered it, and the value always differs from `ren_phys_old`.
- R4: `ren_phys_old` gives the speculative mapping of `ren_dst` before the current instruction.
- R5: After a rename fires, the speculative map entry of `ren_dst` holds `ren_phys_dst`, and the next rename sees it.
- R6: `ren_ready` is high exactly when the free list is not empty. While it is low, `ren_valid` is ignored: nothing is popped and the map does not change.
- R7: A release (`rel_valid` high, `flush` low) pushes `rel_phys_old` onto the tail of the free list and sets the committed entry of `rel_log` to `rel_phys_new`. A release and a rename may happen in the same cycle.
- R8: `flush` takes priority. It copies the committed map into the speculative map and refills the free list with every physical register the committed map does not use, in ascending order. A rename or release requested in the same cycle is ignored, and `ren_ready` is high in the following cycle.
- R9: The rename outputs are combinational. They are valid in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flush | input | 1 | Restore the committed mapping |
| ren_valid | input | 1 | Rename request |
| ren_src_a | input | LW | First logical source |
| ren_src_b | input | LW | Second logical source |
| ren_dst | input | LW | Logical destination |
| ren_ready | output | 1 | Free list not empty |
| ren_phys_a | output | PW | Physical name of first source |
| ren_phys_b | output | PW | Physical name of second source |
| ren_phys_dst | output | PW | Newly allocated physical destination |
| ren_phys_old | output | PW | Previous physical mapping of destination |
| rel_valid | input | 1 | Commit-time release |
| rel_log | input | LW | Logical destination of committing instruction |
| rel_phys_new | input | PW | Physical register it was given |
| rel_phys_old | input | PW | Physical register to return to free list |

## Verification
The bench renames instructions whose source equals their own destination. A design that remapped before the lookup would return the new name as the source. It also drains the free list completely and keeps requesting. A block that popped while empty would hand out stale registers or corrupt the map. Flushes land while releases and renames are in flight and while the free list is partly consumed. A wrong rebuild would show up as a free-list order or content different from the ascending set of unused registers. A release in the same cycle as an allocation would expose a FIFO count that drifts.

// File: rtl/rn_pkg.sv
// Shared helpers for the rename unit.
// Assumes: all counts are positive.
package rn_pkg;
    // Index width that is never zero, so single-entry tables still get a bit.
    function automatic int idx_bits(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/rn_map_table.sv
// Speculative and committed logical-to-physical map tables.
// Does: three combinational read ports on the speculative map, one
// speculative write per allocation, and one committed write per release.
// A flush copies the committed map into the speculative map.
// Assumes: flush has priority over allocation and release in its cycle.
module rn_map_table #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    parameter int LW       = 3,
    parameter int PW       = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 alloc,
    input  logic [LW-1:0]        alloc_dst,
    input  logic [PW-1:0]        alloc_phys,
    input  logic                 rel,
    input  logic [LW-1:0]        rel_log,
    input  logic [PW-1:0]        rel_phys,
    input  logic [LW-1:0]        rd_a,
    input  logic [LW-1:0]        rd_b,
    input  logic [LW-1:0]        rd_d,
    output logic [PW-1:0]        phys_a,
    output logic [PW-1:0]        phys_b,
    output logic [PW-1:0]        phys_d,
    output logic [NUM_LOG*PW-1:0] spec_flat,
    output logic [NUM_LOG*PW-1:0] commit_flat
);
    logic [PW-1:0] spec_q   [NUM_LOG];
    logic [PW-1:0] commit_q [NUM_LOG];

    // Lookups read the map as it stands before this cycle's write.
    assign phys_a = spec_q[rd_a];
    assign phys_b = spec_q[rd_b];
    assign phys_d = spec_q[rd_d];

    // Map state: identity at reset, restore on flush, otherwise update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LOG; i++) begin
                spec_q[i]   <= PW'(i);
                commit_q[i] <= PW'(i);
            end
        end else if (flush) begin
            for (int i = 0; i < NUM_LOG; i++) spec_q[i] <= commit_q[i];
        end else begin
            if (alloc) spec_q[alloc_dst] <= alloc_phys;
            if (rel)   commit_q[rel_log] <= rel_phys;
        end
    end

    // Flattened copies for the free-list rebuild and the checker.
    for (genvar g = 0; g < NUM_LOG; g++) begin : g_flat
        assign spec_flat[g*PW +: PW]   = spec_q[g];
        assign commit_flat[g*PW +: PW] = commit_q[g];
    end
endmodule

// File: rtl/rn_free_list.sv
// FIFO of unassigned physical register numbers.
// Does: pops the head on allocation and pushes released registers at the tail.
// On flush it rebuilds itself from the registers the committed map does not use,
// in ascending order.
// Assumes: no push when full and no pop when empty (the caller gates both).
module rn_free_list #(
    parameter int NUM_LOG  = 8,
    parameter int NUM_PHYS = 16,
    parameter int PW       = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic                  pop,
    input  logic                  push,
    input  logic [PW-1:0]         push_phys,
    input  logic [NUM_LOG*PW-1:0] commit_flat,
    output logic [PW-1:0]         head,
    output logic                  not_empty
);
    localparam int DEPTH = NUM_PHYS - NUM_LOG;
    localparam int PTRW  = rn_pkg::idx_bits(DEPTH);
    localparam int CNTW  = $clog2(DEPTH + 1);

    logic [PW-1:0]   slot_q [DEPTH];
    logic [PTRW-1:0] rd_q, wr_q;
    logic [CNTW-1:0] cnt_q;
    logic [PW-1:0]   reb_list [DEPTH];
    logic [CNTW-1:0] reb_cnt;
    logic [NUM_PHYS-1:0] used;

    // Wrap a pointer at DEPTH, which need not be a power of two.
    function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    assign head      = slot_q[rd_q];
    assign not_empty = (cnt_q != '0);

    // Rebuild image: registers absent from the committed map, ascending.
    always_comb begin
        int n;
        used = '0;
        for (int i = 0; i < NUM_LOG; i++) used[commit_flat[i*PW +: PW]] = 1'b1;
        for (int k = 0; k < DEPTH; k++) reb_list[k] = '0;
        n = 0;
        for (int p = 0; p < NUM_PHYS; p++) begin
            if (!used[p] && n < DEPTH) begin
                reb_list[n] = PW'(p);
                n = n + 1;
            end
        end
        reb_cnt = CNTW'(n);
    end

    // FIFO state: upper registers at reset, rebuild on flush, else push/pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= PW'(NUM_LOG + k);
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= CNTW'(DEPTH);
        end else if (flush) begin
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= reb_list[k];
            rd_q  <= '0;
            wr_q  <= (int'(reb_cnt) == DEPTH) ? '0 : PTRW'(reb_cnt);
            cnt_q <= reb_cnt;
        end else begin
            if (push) begin
                slot_q[wr_q] <= push_phys;
                wr_q         <= bump(wr_q);
            end
            if (pop) rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CNTW'(push) - CNTW'(pop);
        end
    end
endmodule

// File: rtl/rename_unit.sv
// Single-issue register rename unit.
// Does: translates two sources and a destination through the speculative map
// and gives the destination a fresh physical register from the free list. It
// returns the old mapping, which comes back through the release port at commit.
// Assumes: each released old register was handed out by an earlier rename, and
// releases arrive in program order.
module rename_unit #(
    parameter int NUM_LOG    = 8,
    parameter int PHYS_RATIO = 2,
    localparam int NUM_PHYS  = NUM_LOG * PHYS_RATIO,
    localparam int LW        = rn_pkg::idx_bits(NUM_LOG),
    localparam int PW        = rn_pkg::idx_bits(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          ren_valid,
    input  logic [LW-1:0] ren_src_a,
    input  logic [LW-1:0] ren_src_b,
    input  logic [LW-1:0] ren_dst,
    output logic          ren_ready,
    output logic [PW-1:0] ren_phys_a,
    output logic [PW-1:0] ren_phys_b,
    output logic [PW-1:0] ren_phys_dst,
    output logic [PW-1:0] ren_phys_old,
    input  logic          rel_valid,
    input  logic [LW-1:0] rel_log,
    input  logic [PW-1:0] rel_phys_new,
    input  logic [PW-1:0] rel_phys_old
);
    logic                  fire, rel_go, fl_ne;
    logic [PW-1:0]         fl_head;
    logic [NUM_LOG*PW-1:0] spec_flat, commit_flat;

    // Handshake: flush suppresses both the allocation and the release.
    assign fire         = ren_valid && fl_ne && !flush;
    assign rel_go       = rel_valid && !flush;
    assign ren_ready    = fl_ne;
    assign ren_phys_dst = fl_head;

    rn_map_table #(
        .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .LW(LW), .PW(PW)
    ) map_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc(fire), .alloc_dst(ren_dst), .alloc_phys(fl_head),
        .rel(rel_go), .rel_log(rel_log), .rel_phys(rel_phys_new),
        .rd_a(ren_src_a), .rd_b(ren_src_b), .rd_d(ren_dst),
        .phys_a(ren_phys_a), .phys_b(ren_phys_b), .phys_d(ren_phys_old),
        .spec_flat(spec_flat), .commit_flat(commit_flat)
    );

    rn_free_list #(
        .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .PW(PW)
    ) free_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .pop(fire), .push(rel_go), .push_phys(rel_phys_old),
        .commit_flat(commit_flat), .head(fl_head), .not_empty(fl_ne)
    );
endmodule

// File: rtl/rn_checker.sv
// Temporal checks on the rename unit, attached by bind.
// Assumes: the caller never releases a register it did not receive.
module rn_checker #(
    parameter int NUM_LOG = 8,
    parameter int LW      = 3,
    parameter int PW      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  flush,
    input logic                  ren_valid,
    input logic                  ren_ready,
    input logic [LW-1:0]         ren_dst,
    input logic [PW-1:0]         ren_phys_dst,
    input logic [PW-1:0]         ren_phys_old,
    input logic                  rel_valid,
    input logic [LW-1:0]         rel_log,
    input logic [PW-1:0]         rel_phys_new,
    input logic [NUM_LOG*PW-1:0] spec_flat,
    input logic [NUM_LOG*PW-1:0] commit_flat
);
    AST_FRESH_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && !flush) |-> (ren_phys_dst != ren_phys_old)); // R3
    AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && !flush) |=>
        (spec_flat[int'($past(ren_dst))*PW +: PW] == $past(ren_phys_dst))); // R5
    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_ready && !flush) |=> $stable(spec_flat)); // R6
    AST_COMMIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !flush) |=>
        (commit_flat[int'($past(rel_log))*PW +: PW] == $past(rel_phys_new))); // R7
    AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (spec_flat == $past(commit_flat))); // R8
    AST_FLUSH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ren_ready); // R8
endmodule

bind rename_unit rn_checker #(.NUM_LOG(NUM_LOG), .LW(LW), .PW(PW)) chk_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .ren_valid(ren_valid), .ren_ready(ren_ready), .ren_dst(ren_dst),
    .ren_phys_dst(ren_phys_dst), .ren_phys_old(ren_phys_old),
    .rel_valid(rel_valid), .rel_log(rel_log), .rel_phys_new(rel_phys_new),
    .spec_flat(spec_flat), .commit_flat(commit_flat)
);

// File: tb/rename_unit_tb_top.sv
`timescale 1ns/1ps
module rename_unit_tb_top;
    localparam int NL = 8;
    localparam int NP = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush = 1'b0;
    logic       ren_valid = 1'b0;
    logic [2:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic       ren_ready;
    logic [3:0] ren_phys_a, ren_phys_b, ren_phys_dst, ren_phys_old;
    logic       rel_valid = 1'b0;
    logic [2:0] rel_log = '0;
    logic [3:0] rel_phys_new = '0, rel_phys_old = '0;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    int m_spec[NL];
    int m_commit[NL];
    int m_free[$];
    int q_log[$], q_new[$], q_old[$];

    always #2.5 clk = ~clk;

    rename_unit dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .ren_valid(ren_valid), .ren_src_a(ren_src_a), .ren_src_b(ren_src_b),
        .ren_dst(ren_dst), .ren_ready(ren_ready),
        .ren_phys_a(ren_phys_a), .ren_phys_b(ren_phys_b),
        .ren_phys_dst(ren_phys_dst), .ren_phys_old(ren_phys_old),
        .rel_valid(rel_valid), .rel_log(rel_log),
        .rel_phys_new(rel_phys_new), .rel_phys_old(rel_phys_old)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        m_free.delete(); q_log.delete(); q_new.delete(); q_old.delete();
        for (int i = 0; i < NL; i++) begin m_spec[i] = i; m_commit[i] = i; end
        for (int p = NL; p < NP; p++) m_free.push_back(p);
    endfunction

    function automatic void model_flush();
        bit used[NP];
        for (int p = 0; p < NP; p++) used[p] = 1'b0;
        for (int i = 0; i < NL; i++) begin m_spec[i] = m_commit[i]; used[m_commit[i]] = 1'b1; end
        m_free.delete(); q_log.delete(); q_new.delete(); q_old.delete();
        for (int p = 0; p < NP; p++) if (!used[p]) m_free.push_back(p);
    endfunction

    // One cycle: drive at negedge, check combinational outputs, advance model.
    task automatic step(input bit v, input int a, input int b, input int d,
                        input bit rv, input bit fl);
        bit do_rel, can;
        @(negedge clk);
        do_rel = rv && (q_log.size() > 0);
        ren_valid = v; ren_src_a = 3'(a); ren_src_b = 3'(b); ren_dst = 3'(d);
        rel_valid = do_rel; flush = fl;
        if (do_rel) begin
            rel_log = 3'(q_log[0]); rel_phys_new = 4'(q_new[0]); rel_phys_old = 4'(q_old[0]);
        end
        #1;
        can = (m_free.size() != 0);
        chk("R6 ready", int'(ren_ready), int'(can));
        if (v && can && !fl) begin
            chk("R2 src_a", int'(ren_phys_a), m_spec[a]);
            chk("R2 src_b", int'(ren_phys_b), m_spec[b]);
            chk("R3 dst head", int'(ren_phys_dst), m_free[0]);
            chk("R4 old map", int'(ren_phys_old), m_spec[d]);
        end
        if (fl) begin
            model_flush();
        end else begin
            if (v && can) begin
                int np;
                np = m_free.pop_front();
                q_log.push_back(d); q_new.push_back(np); q_old.push_back(m_spec[d]);
                m_spec[d] = np;
            end
            if (do_rel) begin
                m_commit[q_log[0]] = q_new[0];
                m_free.push_back(q_old[0]);
                void'(q_log.pop_front()); void'(q_new.pop_front()); void'(q_old.pop_front());
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state visible on the ports
        chk("R1 ready after reset", int'(ren_ready), 1);
        for (int i = 0; i < NL; i++) begin
            ren_src_a = 3'(i); #0.1;
            chk("R1 identity map", int'(ren_phys_a), i);
        end
        // R1/R3/R9: drain free list in ascending order, R2 src==dst
        for (int i = 0; i < NL; i++) step(1, i, i, i, 0, 0);
        // R6: empty, requests ignored
        step(1, 2, 3, 4, 0, 0);
        step(1, 4, 4, 4, 0, 0);
        // R7: release and rename in the same cycle
        step(1, 4, 0, 4, 1, 0);
        step(1, 4, 5, 4, 1, 0);
        // R2/R5: back-to-back same destination
        step(0, 0, 0, 0, 1, 0);
        step(1, 3, 3, 3, 0, 0);
        step(1, 3, 3, 3, 0, 0);
        // R8: flush with a release and rename pending, then reuse
        step(1, 1, 2, 1, 1, 1);
        step(1, 1, 2, 1, 0, 0);
        step(1, 1, 1, 1, 1, 0);
        // Random traffic
        for (int c = 0; c < 20000; c++) begin
            int r;
            r = int'($urandom % 100);
            step(r < 60, int'($urandom % NL), int'($urandom % NL), int'($urandom % NL),
                 ($urandom % 100) < 45, r == 99);
        end
        // R8: flush after heavy traffic, then drain completely
        step(0, 0, 0, 0, 0, 1);
        for (int i = 0; i < NL + 2; i++) step(1, i % NL, (i + 3) % NL, (i * 5) % NL, 0, 0);
        @(negedge clk);
        ren_valid = 0; rel_valid = 0; flush = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule